// File: doc/BRIEF.md
# Sub-Audio Tone Frequency Meter

This block measures the frequency of a received sub-audio tone without being told in advance which tone to expect. It takes a one-bit digitised signal from an external comparator and runs on a fixed reference clock, nominally 4.00 MHz. The input is first synchronised and cleaned by a three-sample majority filter. The interval between rising edges is then timed, and each period is compared with the one before it. A period that stays within a programmable number of ticks of its predecessor counts as a good period.

Measurement runs in back-to-back windows of `WIN_TICKS` clocks. The default of 490560 clocks gives 122.64 ms at 4 MHz. A window is accepted only when enough of its periods are good. An accepted window produces a 16-bit result: the average good period expressed in units of two reference ticks. Host software reads the result one byte at a time and matches it against its own table of tones. Each new result sets a sticky completion flag. A no-tone flag is raised when windows keep failing.

Top module: `tone_meter`

## Requirements
- R1: After reset `done` and `notone` are 0, and both bytes of the result read 0.
- R2: An input pulse one clock long, in either direction, is removed by the majority filter and has no effect on any period or result.
- R3: A period is the number of clocks between two successive filtered rising edges. The result is floor(sum of the window's good periods / (2 × number of good periods)). `byte_sel`=1 reads result bits 15:8 and `byte_sel`=0 reads bits 7:0.
- R4: A period is good when its absolute difference from the previous period is strictly less than `thresh`. The first period after reset, and the first period after an edge-less gap of 2^PER_W−1 clocks, is kept only as a reference and is not scored.
- R5: A window is accepted only when it holds at least one good period and 4 × good ≥ 3 × scored periods.
- R6: An accepted window whose quotient is nonzero and fits in 16 bits loads the result and sets `done`. In every other case the result keeps its previous value.
- R7: `done` stays at 1 until `clr_done` is pulsed. If a new result arrives in the same cycle as `clr_done`, `done` stays at 1.
- R8: `notone` rises after 3 consecutive failed windows. It clears together with the next loaded result.
- R9: Windows are exactly `WIN_TICKS` clocks long, follow each other without gaps, and the first one starts at the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_in | input | 1 | Digitised sub-audio signal from the comparator |
| thresh | input | TH_W | Period-to-period tolerance in ticks |
| clr_done | input | 1 | Clears the completion flag |
| byte_sel | input | 1 | Selects the result byte: 1 = high, 0 = low |
| result_byte | output | 8 | Selected byte of the 16-bit result |
| done | output | 1 | Sticky flag: a new result has been loaded |
| notone | output | 1 | No tone present: 3 or more windows in a row failed |

## Verification
Any fault in the period timer, the filter or the quality decision becomes visible at the ports within two windows. It shows up as a result that is off from P/2 for a clean square wave of period P, as a result that moves when one-clock glitches are added, or as `done` and `notone` taking the wrong value on stable, alternating or jittered patterns. A fault in the window counter shows as `notone` rising at the wrong multiple of `WIN_TICKS` after reset. A wrong flag update shows up on the very next cycle, as `done` failing to hold or to clear.

// File: rtl/tm_pkg.sv
package tm_pkg;
    // Consecutive failing windows before the no-tone flag is raised.
    localparam int FAIL_LIMIT = 3;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction
endpackage

// File: rtl/tm_in_filter.sv
module tm_in_filter
    import tm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    typedef struct packed {
        logic [1:0] sync;
        logic [2:0] hist;
        logic       filt;
        logic       prev;
    } flt_t;

    flt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], sig_in};
        s_d.hist = {s_q.hist[1:0], s_q.sync[1]};
        s_d.filt = maj3(s_q.hist);
        s_d.prev = s_q.filt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.filt & ~s_q.prev;
endmodule

// File: rtl/tm_period_meter.sv
module tm_period_meter #(
    parameter int PER_W = 18,
    parameter int TH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [TH_W-1:0]  thresh,
    output logic             ev_valid,
    output logic             ev_pass,
    output logic [PER_W-1:0] ev_ticks
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             have;
        logic             sat;
        logic [PER_W-1:0] prev;
        logic             prev_ok;
        logic             ev_valid;
        logic             ev_pass;
        logic [PER_W-1:0] ev_ticks;
    } pm_t;

    pm_t s_d, s_q;
    logic [PER_W-1:0] diff;

    always_comb begin
        s_d          = s_q;
        s_d.ev_valid = 1'b0;
        s_d.ev_pass  = 1'b0;
        diff = (s_q.cnt >= s_q.prev) ? (s_q.cnt - s_q.prev) : (s_q.prev - s_q.cnt);
        if (rise) begin
            if (s_q.have && !s_q.sat) begin
                if (s_q.prev_ok) begin
                    s_d.ev_valid = 1'b1;
                    s_d.ev_pass  = (diff < PER_W'(thresh));
                    s_d.ev_ticks = s_q.cnt;
                end
                s_d.prev    = s_q.cnt;
                s_d.prev_ok = 1'b1;
            end else begin
                s_d.prev_ok = 1'b0;
            end
            s_d.have = 1'b1;
            s_d.sat  = 1'b0;
            s_d.cnt  = PER_W'(1);
        end else if (s_q.cnt == CNT_MAX) begin
            s_d.sat     = 1'b1;
            s_d.prev_ok = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cnt <= PER_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign ev_valid = s_q.ev_valid;
    assign ev_pass  = s_q.ev_pass;
    assign ev_ticks = s_q.ev_ticks;
endmodule

// File: rtl/tm_divider.sv
module tm_divider #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int IDX_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] left;
        logic [NUM_W-1:0] num_sh;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } dv_t;

    dv_t s_d, s_q;
    logic [DEN_W:0] rem_sh;
    logic [DEN_W:0] rem_sub;
    logic           take;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        rem_sh   = {s_q.rem, s_q.num_sh[NUM_W-1]};
        rem_sub  = rem_sh - {1'b0, s_q.den};
        take     = (rem_sh >= {1'b0, s_q.den});
        if (s_q.busy) begin
            s_d.rem    = take ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            s_d.quo    = {s_q.quo[NUM_W-2:0], take};
            s_d.num_sh = {s_q.num_sh[NUM_W-2:0], 1'b0};
            s_d.left   = s_q.left - 1'b1;
            if (s_q.left == IDX_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end else if (start) begin
            s_d.busy   = 1'b1;
            s_d.left   = IDX_W'(NUM_W);
            s_d.num_sh = num;
            s_d.den    = den;
            s_d.rem    = '0;
            s_d.quo    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign quot = s_q.quo;
endmodule

// File: rtl/tone_meter.sv
module tone_meter
    import tm_pkg::*;
#(
    parameter int WIN_TICKS = 490560,
    parameter int PER_W     = 18,
    parameter int TH_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tone_in,
    input  logic [TH_W-1:0] thresh,
    input  logic            clr_done,
    input  logic            byte_sel,
    output logic [7:0]      result_byte,
    output logic            done,
    output logic            notone
);
    localparam int WC_W  = $clog2(WIN_TICKS);
    localparam int CNT_W = $clog2(WIN_TICKS + 1);
    localparam int SUM_W = $clog2(WIN_TICKS + (2 ** PER_W) + 1);
    localparam int DEN_W = CNT_W + 1;
    localparam logic [WC_W-1:0] WIN_LAST = WC_W'(WIN_TICKS - 1);

    typedef struct packed {
        logic [WC_W-1:0]  win_cnt;
        logic [CNT_W-1:0] n_sc;
        logic [CNT_W-1:0] n_ps;
        logic [SUM_W-1:0] sum;
        logic [1:0]       fails;
        logic             notone;
        logic             done;
        logic [15:0]      result;
    } top_t;

    top_t s_d, s_q;

    logic             rise;
    logic             ev_valid, ev_pass;
    logic [PER_W-1:0] ev_ticks;
    logic             div_start, div_busy, div_done;
    logic [SUM_W-1:0] div_quot;
    logic [SUM_W-1:0] sum_n;
    logic [CNT_W-1:0] sc_n, ps_n;
    logic             win_end, win_good, quot_ok;
    logic             res_load, fail_evt;
    logic [CNT_W+1:0] good4, scored3;

    tm_in_filter u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (tone_in),
        .rise   (rise)
    );

    tm_period_meter #(.PER_W(PER_W), .TH_W(TH_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .thresh   (thresh),
        .ev_valid (ev_valid),
        .ev_pass  (ev_pass),
        .ev_ticks (ev_ticks)
    );

    tm_divider #(.NUM_W(SUM_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (sum_n),
        .den   ({ps_n, 1'b0}),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    always_comb begin
        s_d = s_q;

        // accumulate this cycle's period into the running window totals
        sc_n  = s_q.n_sc;
        ps_n  = s_q.n_ps;
        sum_n = s_q.sum;
        if (ev_valid) begin
            sc_n = s_q.n_sc + 1'b1;
            if (ev_pass) begin
                ps_n  = s_q.n_ps + 1'b1;
                sum_n = s_q.sum + SUM_W'(ev_ticks);
            end
        end

        win_end   = (s_q.win_cnt == WIN_LAST);
        good4     = {ps_n, 2'b00};
        scored3   = (CNT_W+2)'(sc_n) + (CNT_W+2)'({sc_n, 1'b0});
        win_good  = (ps_n != '0) && (good4 >= scored3);
        div_start = 1'b0;
        fail_evt  = 1'b0;
        res_load  = 1'b0;

        if (win_end) begin
            s_d.win_cnt = '0;
            s_d.n_sc    = '0;
            s_d.n_ps    = '0;
            s_d.sum     = '0;
            if (win_good && !div_busy) div_start = 1'b1;
            else                       fail_evt  = 1'b1;
        end else begin
            s_d.win_cnt = s_q.win_cnt + 1'b1;
            s_d.n_sc    = sc_n;
            s_d.n_ps    = ps_n;
            s_d.sum     = sum_n;
        end

        quot_ok = ((div_quot >> 16) == '0) && (div_quot[15:0] != 16'h0);
        if (div_done) begin
            if (quot_ok) res_load = 1'b1;
            else         fail_evt = 1'b1;
        end

        if (clr_done) s_d.done = 1'b0;

        if (res_load) begin
            s_d.result = div_quot[15:0];
            s_d.done   = 1'b1;
            s_d.fails  = '0;
            s_d.notone = 1'b0;
        end else if (fail_evt) begin
            if (s_q.fails != 2'd3) s_d.fails = s_q.fails + 1'b1;
            if (32'(s_q.fails) + 1 >= FAIL_LIMIT) s_d.notone = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign result_byte = byte_sel ? s_q.result[15:8] : s_q.result[7:0];
    assign done        = s_q.done;
    assign notone      = s_q.notone;
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int WIN_TICKS = 490560
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_done,
    input logic       done,
    input logic       notone,
    input logic [15:0] result,
    input logic       res_load,
    input logic       fail_evt,
    input logic       win_end
);
    localparam int W = $clog2(WIN_TICKS + 1);
    logic [W-1:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       since <= '0;
        else if (win_end) since <= '0;
        else              since <= since + 1'b1;
    end

    // R6
    done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (result != 16'h0));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_load |=> $stable(result));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_done) |=> done);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !res_load) |=> !done);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> done);

    // R8
    notone_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_load |=> !notone);

    // R8
    notone_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(notone) |-> $past(fail_evt));

    // R9
    win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (32'(since) == WIN_TICKS - 1));
endmodule

bind tone_meter tm_checker #(.WIN_TICKS(WIN_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_done (clr_done),
    .done     (done),
    .notone   (notone),
    .result   (s_q.result),
    .res_load (res_load),
    .fail_evt (fail_evt),
    .win_end  (win_end)
);

// File: tb/sim_tone_meter.sv
`timescale 1ns/1ps
module sim_tone_meter;
    localparam int WIN = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_in = 1'b0;
    logic [7:0] thresh = 8'd3;
    logic       clr_done = 1'b0;
    logic       byte_sel = 1'b0;
    logic [7:0] result_byte;
    logic       done, notone;

    int checks = 0;
    int errors = 0;

    // stimulus pattern: list of (high, low) phase lengths, repeated
    int  pat_h [0:15];
    int  pat_l [0:15];
    int  pat_n = 0;
    bit  run = 1'b0;
    bit  glitch = 1'b0;

    always #5 clk = ~clk;

    tone_meter #(.WIN_TICKS(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .tone_in(tone_in), .thresh(thresh),
        .clr_done(clr_done), .byte_sel(byte_sel), .result_byte(result_byte),
        .done(done), .notone(notone)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pattern generator
    initial begin
        forever begin
            if (!run || pat_n == 0) begin
                @(negedge clk);
                tone_in = 1'b0;
            end else begin
                for (int i = 0; i < pat_n; i++) begin
                    for (int k = 0; k < pat_h[i]; k++) begin
                        @(negedge clk);
                        tone_in = (glitch && k == pat_h[i] / 2) ? 1'b0 : 1'b1;
                    end
                    for (int k = 0; k < pat_l[i]; k++) begin
                        @(negedge clk);
                        tone_in = (glitch && k == pat_l[i] / 2) ? 1'b1 : 1'b0;
                    end
                end
            end
        end
    end

    task automatic set_square(input int p);
        pat_h[0] = p / 2;
        pat_l[0] = p - p / 2;
        pat_n = 1;
        run = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr_done = 1'b1;
        @(negedge clk);
        clr_done = 1'b0;
    endtask

    task automatic read_result(output int r);
        int lo, hi;
        byte_sel = 1'b0;
        #1 lo = result_byte;
        byte_sel = 1'b1;
        #1 hi = result_byte;
        byte_sel = 1'b0;
        r = hi * 256 + lo;
    endtask

    // let the current pattern fill whole windows, then wait for a fresh result
    task automatic measure(output bit got, output int r);
        wait_cyc(2 * WIN);
        pulse_clr();
        got = 1'b0;
        for (int i = 0; i < 2 * WIN + 200; i++) begin
            @(negedge clk);
            if (done) begin got = 1'b1; break; end
        end
        read_result(r);
    endtask

    initial begin
        #(10 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit got;
        int r;
        int sweep [0:8] = '{8, 11, 17, 26, 40, 63, 97, 150, 231};

        wait_cyc(3);
        // R1 reset state
        check(done == 1'b0, "R1 done", done, 0);
        check(notone == 1'b0, "R1 notone", notone, 0);
        read_result(r);
        check(r == 0, "R1 result", r, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 / R9: no input, notone only after the third window ends
        wait_cyc(WIN * 5 / 2);
        check(notone == 1'b0, "R8 R9 notone after two windows", notone, 0);
        check(done == 1'b0, "R6 no result without tone", done, 0);
        wait_cyc(WIN);
        check(notone == 1'b1, "R8 R9 notone after three windows", notone, 1);

        // R3 / R6 sweep of clean square waves
        foreach (sweep[i]) begin
            set_square(sweep[i]);
            measure(got, r);
            check(got, "R6 done after clean tone", got, 1);
            check(r == sweep[i] / 2, "R3 result = period/2", r, sweep[i] / 2);
            if (i == 0) check(notone == 1'b0, "R8 notone cleared", notone, 0);
        end

        // R3 high byte
        set_square(600);
        measure(got, r);
        byte_sel = 1'b1;
        #1 check(result_byte == 8'h01, "R3 high byte", result_byte, 1);
        byte_sel = 1'b0;
        #1 check(result_byte == 8'h2C, "R3 low byte", result_byte, 8'h2C);

        // R2 one-clock glitches in both phases
        glitch = 1'b1;
        set_square(40);
        measure(got, r);
        check(got && r == 20, "R2 glitches ignored", r, 20);
        glitch = 1'b0;

        // R5 ten good periods then one outlier: about 80 percent pass
        for (int i = 0; i < 10; i++) begin pat_h[i] = 20; pat_l[i] = 20; end
        pat_h[10] = 20; pat_l[10] = 40;
        pat_n = 11;
        measure(got, r);
        check(got && r == 20, "R5 mostly-good window accepted", r, 20);

        // R5 / R8 alternating 40/60: every scored period fails
        pat_h[0] = 20; pat_l[0] = 20; pat_h[1] = 20; pat_l[1] = 40; pat_n = 2;
        pulse_clr();
        wait_cyc(WIN * 21 / 5);
        check(done == 1'b0, "R5 jitter gives no result", done, 0);
        check(notone == 1'b1, "R8 jitter raises notone", notone, 1);

        // R4 boundary: 40/44 alternation, difference 4
        thresh = 8'd4;
        pat_h[0] = 20; pat_l[0] = 20; pat_h[1] = 20; pat_l[1] = 24; pat_n = 2;
        wait_cyc(2 * WIN);
        pulse_clr();
        wait_cyc(2 * WIN);
        check(done == 1'b0, "R4 diff equal to thresh fails", done, 0);
        thresh = 8'd5;
        measure(got, r);
        check(got && (r == 20 || r == 21), "R4 diff below thresh passes", r, 21);
        check(notone == 1'b0, "R8 notone cleared by result", notone, 0);

        // R7 done holds, then clears
        wait_cyc(20);
        check(done == 1'b1, "R7 done holds", done, 1);
        pulse_clr();
        check(done == 1'b0, "R7 done cleared", done, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule